// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block sequences the transfers of one DMA channel in single-transfer mode. Software programs a base address, a base count, an 8-bit page value and a mode. The engine then watches the peripheral request line. For each serviced request it asks for the bus, waits for the grant, and runs exactly one transfer cycle. During that cycle it acknowledges the peripheral and drives a 24-bit physical address. After the cycle it gives the bus back.

The 16-bit address counter increments after every transfer. The page value never increments, so a run of transfers wraps inside its 64K-byte window (byte channel) or 128K-byte window (word channel). The count is programmed as one less than the number of transfers. The last transfer is the one that moves the count from zero to 0xFFFF. On that transfer the engine pulses a terminal-count output and sets a sticky flag. It then either masks itself or, in autoinitialize mode, reloads the address and count from the base copies. In cascade mode the channel forwards the request and the grant without touching its address or count. Decoding the host registers and arbitrating between channels are left to the surrounding logic.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset, `hold_req_o`, `dack_o`, `tc_o`, `addr_valid_o` and `tc_flag_o` are 0, `masked_o` is 1 and `cur_cnt_o` is 0.
- R2: A programmed count C gives exactly C+1 transfers. `tc_o` is high only during the last of them, the one that starts with `cur_cnt_o` at 0.
- R3: On a byte channel (`word_i`=0), `bus_addr_o` = {page[7:0], addr[15:0]}. The address counter goes up by 1 per transfer and wraps from 0xFFFF to 0x0000 without changing the page.
- R4: On a word channel (`word_i`=1), `bus_addr_o` = {page[7:1], addr[15:0], 1'b0}. Page bit 0 is ignored, and the counter wraps inside a 128K-byte window.
- R5: In single mode with the channel unmasked, `dreq_i` high in an idle cycle raises `hold_req_o` on the next cycle. `dack_o` and `addr_valid_o` are high for exactly one cycle: the cycle after `hold_ack_i` is sampled high. `hold_req_o` then falls, and no new request starts until `hold_ack_i` is low.
- R6: While `masked_o` is 1, `dreq_i` starts no request and leaves the count unchanged. `mask_set_i` sets the mask and `mask_clr_i` clears it.
- R7: At terminal count without autoinitialize, `masked_o` becomes 1, `tc_flag_o` becomes 1 and `cur_cnt_o` reads 0xFFFF.
- R8: At terminal count with autoinitialize (`autoinit_i`=1), the address and count reload from the base values. `tc_flag_o` becomes 1 and the mask stays clear.
- R9: In cascade mode (`cascade_i`=1) and unmasked, `hold_req_o` follows `dreq_i` and `dack_o` follows `hold_ack_i` in the same cycle. `addr_valid_o` stays 0 and the count does not change.
- R10: A `load_i` pulse loads the base and current registers, the page and the mode, clears `tc_flag_o`, and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load the programming values |
| base_addr_i | input | 16 | Start address (bytes or words) |
| base_cnt_i | input | 16 | Number of transfers minus one |
| page_i | input | 8 | Upper address bits |
| word_i | input | 1 | 1 selects a word channel |
| autoinit_i | input | 1 | Reload at terminal count |
| cascade_i | input | 1 | Request/grant pass-through |
| mask_set_i | input | 1 | Set the channel mask |
| mask_clr_i | input | 1 | Clear the channel mask |
| dreq_i | input | 1 | Peripheral request |
| hold_ack_i | input | 1 | Bus grant |
| hold_req_o | output | 1 | Bus request |
| dack_o | output | 1 | Peripheral acknowledge |
| addr_valid_o | output | 1 | Address drive cycle |
| bus_addr_o | output | 24 | Physical address |
| tc_o | output | 1 | Terminal-count pulse |
| tc_flag_o | output | 1 | Sticky terminal-count flag |
| masked_o | output | 1 | Channel mask state |
| cur_cnt_o | output | 16 | Current count |

## Verification
Some rules are checked by assertions on every cycle. An acknowledge comes only after a sampled grant and lasts a single cycle. A word address always has bit 0 clear. The page never moves because of a transfer. Terminal count leaves either 0xFFFF with the mask set, or the reloaded base. The count holds in cascade mode or while masked. Other behaviour only shows up in the bench's scenarios: the exact number of transfers per count, address wrap at the window edge, page bit 0 being dropped, the reload restarting at the base address, and the same-cycle pass-through in cascade mode.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_XFER = 2'd2,
    S_REL  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic word;
    logic autoinit;
    logic cascade;
  } chan_mode_t;
endpackage

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  chan_mode_t        mode_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  cur_cnt_o,
  output logic [PAGE_W-1:0] page_o,
  output chan_mode_t        mode_o,
  output logic              masked_o,
  output logic              tc_flag_o,
  output logic              last_o
);
  localparam logic [CNT_W-1:0] CNT_ALL1 = '1;

  logic [ADDR_W-1:0] base_addr_q, cur_addr_q;
  logic [CNT_W-1:0]  base_cnt_q, cur_cnt_q;
  logic [PAGE_W-1:0] page_q;
  chan_mode_t        mode_q;
  logic              mask_q, tcf_q;
  logic              hit_tc;

  assign last_o = (cur_cnt_q == '0);
  assign hit_tc = step_i && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= '0;
      tcf_q       <= 1'b0;
    end else if (load_i) begin
      base_addr_q <= base_addr_i;
      base_cnt_q  <= base_cnt_i;
      cur_addr_q  <= base_addr_i;
      cur_cnt_q   <= base_cnt_i;
      page_q      <= page_i;
      mode_q      <= mode_i;
      tcf_q       <= 1'b0;
    end else if (step_i) begin
      if (hit_tc) begin
        tcf_q <= 1'b1;
        if (mode_q.autoinit) begin
          cur_addr_q <= base_addr_q;
          cur_cnt_q  <= base_cnt_q;
        end else begin
          cur_addr_q <= cur_addr_q + ADDR_W'(1);
          cur_cnt_q  <= CNT_ALL1;
        end
      end else begin
        cur_addr_q <= cur_addr_q + ADDR_W'(1);
        cur_cnt_q  <= cur_cnt_q - CNT_W'(1);
      end
    end
  end

  // terminal count masking wins over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            mask_q <= 1'b1;
    else if (hit_tc && !mode_q.autoinit)    mask_q <= 1'b1;
    else if (mask_set_i)                    mask_q <= 1'b1;
    else if (mask_clr_i)                    mask_q <= 1'b0;
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q;
  assign page_o     = page_q;
  assign mode_o     = mode_q;
  assign masked_o   = mask_q;
  assign tc_flag_o  = tcf_q;

  a_r7_tc_masks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !mode_q.autoinit && !load_i) |=> (mask_q && tcf_q && cur_cnt_q == CNT_ALL1));

  a_r8_tc_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && mode_q.autoinit && !load_i) |=> (cur_cnt_q == base_cnt_q && cur_addr_q == base_addr_q && tcf_q));

  a_r3_page_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> $stable(page_q));

  a_r10_load_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !tcf_q);
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  input  logic hold_ack_i,
  input  logic masked_i,
  input  logic cascade_i,
  output logic hold_req_o,
  output logic dack_o,
  output logic step_o
);
  seq_state_e state_q, state_d;
  logic       single_go;

  assign single_go = dreq_i && !masked_i && !cascade_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (single_go)   state_d = S_REQ;
      S_REQ:  if (hold_ack_i)  state_d = S_XFER;
      S_XFER:                  state_d = S_REL;
      S_REL:  if (!hold_ack_i) state_d = S_IDLE;
      default:                 state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  logic pass_en;
  assign pass_en = cascade_i && !masked_i;

  always_comb begin
    hold_req_o = (state_q == S_REQ) || (state_q == S_XFER) || (pass_en && dreq_i);
    dack_o     = (state_q == S_XFER) || (pass_en && hold_ack_i);
    step_o     = (state_q == S_XFER);
  end

  a_r5_xfer_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_XFER) |-> $past(hold_ack_i));

  a_r5_one_cycle_dack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  a_r6_masked_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && masked_i) |=> (state_q == S_IDLE));
endmodule

// File: rtl/dma_xfer_amap.sv
module dma_xfer_amap #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int BUS_W = ADDR_W + PAGE_W
) (
  input  logic              word_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BUS_W-1:0]  bus_addr_o
);
  // word channel: counter shifted up one, page bit 0 dropped
  assign bus_addr_o = word_i ? {page_i[PAGE_W-1:1], addr_i, 1'b0}
                             : {page_i, addr_i};
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int BUS_W = ADDR_W + PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              word_i,
  input  logic              autoinit_i,
  input  logic              cascade_i,
  input  logic              mask_set_i,
  input  logic              mask_clr_i,
  input  logic              dreq_i,
  input  logic              hold_ack_i,
  output logic              hold_req_o,
  output logic              dack_o,
  output logic              addr_valid_o,
  output logic [BUS_W-1:0]  bus_addr_o,
  output logic              tc_o,
  output logic              tc_flag_o,
  output logic              masked_o,
  output logic [CNT_W-1:0]  cur_cnt_o
);
  chan_mode_t        mode_in, mode_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [PAGE_W-1:0] page_q;
  logic              step, last, masked;

  assign mode_in = '{word: word_i, autoinit: autoinit_i, cascade: cascade_i};

  dma_xfer_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_regs (
    .clk_i, .rst_ni, .load_i, .base_addr_i, .base_cnt_i, .page_i,
    .mode_i(mode_in), .mask_set_i, .mask_clr_i, .step_i(step),
    .cur_addr_o(cur_addr), .cur_cnt_o, .page_o(page_q), .mode_o(mode_q),
    .masked_o(masked), .tc_flag_o, .last_o(last)
  );

  dma_xfer_seq u_seq (
    .clk_i, .rst_ni, .dreq_i, .hold_ack_i, .masked_i(masked),
    .cascade_i(mode_q.cascade), .hold_req_o, .dack_o, .step_o(step)
  );

  dma_xfer_amap #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_amap (
    .word_i(mode_q.word), .page_i(page_q), .addr_i(cur_addr), .bus_addr_o
  );

  assign addr_valid_o = step;
  assign tc_o         = step && last;
  assign masked_o     = masked;

  a_r4_word_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && mode_q.word) |-> !bus_addr_o[0]);

  a_r9_cascade_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.cascade && !load_i) |=> $stable(cur_cnt_o));

  a_r9_cascade_no_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q.cascade |-> !addr_valid_o);

  a_r2_tc_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (dack_o && addr_valid_o));
endmodule

// File: tb/dma_xfer_engine_bench.sv
`timescale 1ns/1ps
module dma_xfer_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        load = 0, word = 0, ainit = 0, casc = 0, mset = 0, mclr = 0, dreq = 0, hack = 0;
  logic [15:0] baddr = 0, bcnt = 0;
  logic [7:0]  page = 0;
  logic        hreq, dack, aval, tc, tcf, msk;
  logic [23:0] baddr_o;
  logic [15:0] ccnt;

  dma_xfer_engine u_dma_xfer_engine (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .base_addr_i(baddr), .base_cnt_i(bcnt),
    .page_i(page), .word_i(word), .autoinit_i(ainit), .cascade_i(casc),
    .mask_set_i(mset), .mask_clr_i(mclr), .dreq_i(dreq), .hold_ack_i(hack),
    .hold_req_o(hreq), .dack_o(dack), .addr_valid_o(aval), .bus_addr_o(baddr_o),
    .tc_o(tc), .tc_flag_o(tcf), .masked_o(msk), .cur_cnt_o(ccnt)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic prog(input logic w, input logic ai, input logic cs, input logic [7:0] pg,
                      input logic [15:0] a, input logic [15:0] c);
    word = w; ainit = ai; casc = cs; page = pg; baddr = a; bcnt = c; load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic unmask();
    mclr = 1; @(negedge clk); mclr = 0;
  endtask

  task automatic xfer(output logic [23:0] a, output logic t);
    dreq = 1; @(negedge clk);
    chk("R5 hold_req", 32'(hreq), 1);
    chk("R5 no early dack", 32'(dack), 0);
    hack = 1; dreq = 0; @(negedge clk);
    chk("R5 dack", 32'(dack), 1);
    chk("R5 addr_valid", 32'(aval), 1);
    a = baddr_o; t = tc;
    @(negedge clk);
    chk("R5 dack one cycle", 32'(dack), 0);
    chk("R5 hold released", 32'(hreq), 0);
    hack = 0; @(negedge clk);
  endtask

  typedef struct packed {
    logic        w;
    logic [7:0]  pg;
    logic [15:0] a;
    logic [15:0] c;
    logic [7:0]  n;
    logic [23:0] first;
    logic [23:0] last;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h12, 16'h3400, 16'd2, 8'd3, 24'h123400, 24'h123402},
    '{1'b0, 8'h05, 16'hFFFE, 16'd2, 8'd3, 24'h05FFFE, 24'h050000},
    '{1'b1, 8'h13, 16'h8000, 16'd1, 8'd2, 24'h130000, 24'h130002},
    '{1'b1, 8'h20, 16'hFFFF, 16'd1, 8'd2, 24'h21FFFE, 24'h200000},
    '{1'b0, 8'hFF, 16'h00AA, 16'd0, 8'd1, 24'hFF00AA, 24'hFF00AA}
  };

  initial begin
    logic [23:0] a;
    logic        t;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hold_req", 32'(hreq), 0);
    chk("R1 dack", 32'(dack), 0);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 masked", 32'(msk), 1);
    chk("R1 tc_flag", 32'(tcf), 0);
    chk("R1 count", 32'(ccnt), 0);
    rst_n = 1; @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      prog(VECS[i].w, 0, 0, VECS[i].pg, VECS[i].a, VECS[i].c);
      unmask();
      for (int k = 0; k < int'(VECS[i].n); k++) begin
        xfer(a, t);
        if (k == 0) chk(VECS[i].w ? "R4 first addr" : "R3 first addr", 32'(a), 32'(VECS[i].first));
        if (k == int'(VECS[i].n) - 1) begin
          chk(VECS[i].w ? "R4 last addr" : "R3 last addr", 32'(a), 32'(VECS[i].last));
          chk("R2 tc on last", 32'(t), 1);
        end else begin
          chk("R2 no early tc", 32'(t), 0);
        end
      end
      chk("R7 masked", 32'(msk), 1);
      chk("R7 flag", 32'(tcf), 1);
      chk("R7 count ffff", 32'(ccnt), 32'hFFFF);
    end

    // R6: masked after terminal count, request ignored
    dreq = 1; repeat (3) @(negedge clk);
    chk("R6 no hold while masked", 32'(hreq), 0);
    dreq = 0;
    // R10: load clears flag, mask untouched
    prog(0, 0, 0, 8'h01, 16'h0000, 16'd5);
    chk("R10 flag cleared", 32'(tcf), 0);
    chk("R10 mask kept", 32'(msk), 1);
    chk("R10 count loaded", 32'(ccnt), 5);
    dreq = 1; repeat (3) @(negedge clk);
    chk("R6 count unchanged", 32'(ccnt), 5);
    chk("R6 no hold", 32'(hreq), 0);
    dreq = 0; @(negedge clk);
    unmask(); mset = 1; @(negedge clk); mset = 0;
    chk("R6 mask_set", 32'(msk), 1);

    // R8 autoinit
    prog(0, 1, 0, 8'h40, 16'h0010, 16'd1);
    unmask();
    xfer(a, t); chk("R8 addr0", 32'(a), 32'h400010); chk("R8 tc0", 32'(t), 0);
    xfer(a, t); chk("R8 addr1", 32'(a), 32'h400011); chk("R8 tc1", 32'(t), 1);
    chk("R8 count reload", 32'(ccnt), 1);
    chk("R8 mask clear", 32'(msk), 0);
    chk("R8 flag", 32'(tcf), 1);
    xfer(a, t); chk("R8 addr reload", 32'(a), 32'h400010);

    // R9 cascade
    mset = 1; @(negedge clk); mset = 0;
    prog(0, 0, 1, 8'h00, 16'h1234, 16'd7);
    unmask();
    dreq = 1; #1;
    chk("R9 hold follows dreq", 32'(hreq), 1);
    hack = 1; #1;
    chk("R9 dack follows ack", 32'(dack), 1);
    chk("R9 no addr", 32'(aval), 0);
    @(negedge clk); @(negedge clk);
    chk("R9 count held", 32'(ccnt), 7);
    dreq = 0; #1;
    chk("R9 hold drops", 32'(hreq), 0);
    hack = 0; #1;
    chk("R9 dack drops", 32'(dack), 0);
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule